// File: doc/BRIEF.md
# Host Packet Command Decoder with Underrun Purge

This block reads the output side of the tagged transmit FIFO inside a USB host protocol engine. Each FIFO entry carries a tag beside its data word. When the schedule controller asks for a packet, the block reads the command entry at the head of the FIFO. It splits the entry into PID, toggle, endpoint type, speed, device address and endpoint number, and holds these fields for the packet builder until the builder accepts them. If the token carries payload, the block then forwards payload words to the PHY side until it reaches the end-of-packet entry. It always ends with a one-cycle completion strobe and a two-bit status.

If the PHY side asks for data and the FIFO has none, the packet is corrupted with a forced bad CRC. The block then waits out a bus-timeout interval. After that it discards stale payload until the FIFO is empty or a start-of-packet entry reaches the head. That entry stays in the FIFO, so a retry command is never damaged. A malformed command entry never stalls the block and is never used as a frame number. It produces an error status instead. SOF requests are granted only while no packet is in progress, and they never touch the FIFO.

Top module: `host_pkt_cmd_engine`

## Requirements
- R1: Out of reset, the block is idle. `done`, `fifo_rd`, `hdr_valid`, `tx_valid`, `tx_bad_crc` and `sof_ack` are all low.
- R2: An accepted command entry (tag 0) is decoded as follows. PID is bits 3:0, toggle is bits 5:4, endpoint type is bits 7:6, speed is bits 9:8, device address is bits 22:16 and endpoint number is bits 29:23. The fields are presented while `hdr_valid` is high.
- R3: The valid PIDs are OUT 4'b0001, IN 4'b1001, SETUP 4'b1101 and PING 4'b0100. OUT and SETUP go on to a payload phase. IN and PING complete with status 2'b00 as soon as `hdr_ack` is seen.
- R4: In the payload phase, while `phy_rdy` is high, each head entry whose tag is neither 0 nor 2 is popped and shown on `tx_data` with `tx_valid`. An entry with tag 2 (end of packet) is popped and completes the transfer with status 2'b00.
- R5: In the payload phase, an underrun occurs when `phy_rdy` is high and the FIFO is empty or its head has tag 0. The block then pulses `tx_bad_crc` for one cycle without popping, and enters the bus-timeout wait.
- R6: The bus-timeout wait lasts TOUT_CYC cycles and pops nothing. The block then pops every entry until the FIFO is empty or a tag-0 entry is at the head. The tag-0 entry is not popped. The transfer completes with status 2'b01.
- R7: A command is rejected with status 2'b10 if the FIFO is empty, if the head tag is nonzero, or if the PID is not one of the four valid codes. A non-empty rejected entry is popped, no header is presented, and no pop ever happens while the FIFO is empty.
- R8: `done` is a one-cycle strobe. Exactly one is produced for each run request taken while `run_pkt` is held high.
- R9: `sof_ack` follows `sof_req` only while the block is idle. An SOF request takes priority over a waiting `run_pkt`, and an SOF grant pops no FIFO entry.
- R10: The header fields and `hdr_valid` stay unchanged until `hdr_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_pkt | input | 1 | Packet request, held high until `done` |
| sof_req | input | 1 | SOF request from the frame timer |
| sof_ack | output | 1 | SOF grant, only while idle |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_tag | input | TAG_W | Tag of the head entry (0 command, 2 end of packet, others payload) |
| fifo_data | input | DATA_W | Data of the head entry |
| fifo_rd | output | 1 | Pop the head entry |
| hdr_valid | output | 1 | Decoded header presented |
| hdr_ack | input | 1 | Packet builder accepts the header |
| hdr_pid | output | 4 | Token PID |
| hdr_toggle | output | 2 | Data toggle |
| hdr_ep_type | output | 2 | Endpoint type |
| hdr_speed | output | 2 | Endpoint speed |
| hdr_addr | output | 7 | Device address |
| hdr_ep | output | 7 | Endpoint number |
| phy_rdy | input | 1 | PHY side wants a payload word |
| tx_valid | output | 1 | Payload word on `tx_data` |
| tx_data | output | DATA_W | Payload word |
| tx_bad_crc | output | 1 | Force a bad CRC on the current packet |
| done | output | 1 | Completion strobe |
| done_status | output | 2 | 00 success, 01 underrun, 10 command error |

## Verification
The bench builds the block with TOUT_CYC set to 3. With this short value, stale entries can be pushed while the bus-timeout wait is running, so the purge is tested both when it stops at a retry command and when it stops on an empty FIFO. DATA_W stays at 32, so every field position in the command word is reached by random commands. The PHY-ready and header-acknowledge inputs are randomized, which makes the header hold and interleaved SOF requests occur in many different cycles.

// File: rtl/host_pkt_cmd_engine.sv
module host_pkt_cmd_engine #(
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int TOUT_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_pkt,
  input  logic              sof_req,
  output logic              sof_ack,
  input  logic              fifo_empty,
  input  logic [TAG_W-1:0]  fifo_tag,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic              hdr_valid,
  input  logic              hdr_ack,
  output logic [3:0]        hdr_pid,
  output logic [1:0]        hdr_toggle,
  output logic [1:0]        hdr_ep_type,
  output logic [1:0]        hdr_speed,
  output logic [6:0]        hdr_addr,
  output logic [6:0]        hdr_ep,
  input  logic              phy_rdy,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_bad_crc,
  output logic              done,
  output logic [1:0]        done_status
);
  localparam int CW = $clog2(TOUT_CYC + 1);
  localparam logic [TAG_W-1:0] TAG_SOP = '0;
  localparam logic [TAG_W-1:0] TAG_EOP = TAG_W'(2);
  localparam logic [1:0] ST_OK = 2'b00, ST_UNDER = 2'b01, ST_ERR = 2'b10;
  localparam logic [3:0] PID_OUT = 4'b0001, PID_IN = 4'b1001,
                         PID_SETUP = 4'b1101, PID_PING = 4'b0100;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_HDR, S_STRM, S_WAIT, S_PURGE} st_t;
  st_t st;
  logic [31:0]   cmd_q;
  logic [CW-1:0] cnt;

  wire head_sop = !fifo_empty && (fifo_tag == TAG_SOP);
  wire head_eop = !fifo_empty && (fifo_tag == TAG_EOP);
  wire [3:0] pid_in = fifo_data[3:0];
  wire pid_ok = (pid_in == PID_OUT) || (pid_in == PID_IN) ||
                (pid_in == PID_SETUP) || (pid_in == PID_PING);
  wire cmd_good = head_sop && pid_ok;
  wire starve = phy_rdy && (fifo_empty || fifo_tag == TAG_SOP);
  wire has_payload = (cmd_q[3:0] == PID_OUT) || (cmd_q[3:0] == PID_SETUP);

  assign hdr_pid     = cmd_q[3:0];
  assign hdr_toggle  = cmd_q[5:4];
  assign hdr_ep_type = cmd_q[7:6];
  assign hdr_speed   = cmd_q[9:8];
  assign hdr_addr    = cmd_q[22:16];
  assign hdr_ep      = cmd_q[29:23];
  assign hdr_valid   = (st == S_HDR);
  assign sof_ack     = (st == S_IDLE) && sof_req;
  assign tx_data     = fifo_data;
  assign tx_bad_crc  = (st == S_STRM) && starve;
  assign tx_valid    = (st == S_STRM) && phy_rdy && !fifo_empty &&
                       !head_sop && !head_eop;

  always_comb begin
    case (st)
      S_CMD:   fifo_rd = !fifo_empty;
      S_STRM:  fifo_rd = phy_rdy && !fifo_empty && !head_sop;
      S_PURGE: fifo_rd = !fifo_empty && !head_sop;
      default: fifo_rd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cmd_q       <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      done_status <= ST_OK;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (run_pkt && !sof_req) st <= S_CMD;
        S_CMD: begin
          if (cmd_good) begin
            cmd_q <= fifo_data[31:0];
            st    <= S_HDR;
          end else begin
            done <= 1'b1; done_status <= ST_ERR; st <= S_IDLE;
          end
        end
        S_HDR: if (hdr_ack) begin
          if (has_payload) st <= S_STRM;
          else begin done <= 1'b1; done_status <= ST_OK; st <= S_IDLE; end
        end
        S_STRM: begin
          if (starve) begin
            cnt <= '0; st <= S_WAIT;
          end else if (phy_rdy && head_eop) begin
            done <= 1'b1; done_status <= ST_OK; st <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (cnt == CW'(TOUT_CYC - 1)) st <= S_PURGE;
          else cnt <= cnt + 1'b1;
        end
        S_PURGE: if (fifo_empty || head_sop) begin
          done <= 1'b1; done_status <= ST_UNDER; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_rd);
  // R6
  sop_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && fifo_tag == TAG_SOP) |-> (st == S_CMD));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ack) |=> (hdr_valid && $stable(cmd_q)));
  // R9
  sof_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_ack |-> (!fifo_rd && !hdr_valid && !tx_valid));
  // R5
  crc_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bad_crc |=> (st == S_WAIT && !fifo_rd && !done));
endmodule

// File: tb/tb_host_pkt_cmd_engine.sv
module tb_host_pkt_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int TOUT = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, run_pkt = 1'b0, sof_req = 1'b0, hdr_ack = 1'b0, phy_rdy = 1'b0;
  logic sof_ack, fifo_empty, fifo_rd, hdr_valid, tx_valid, tx_bad_crc, done;
  logic [3:0] fifo_tag, hdr_pid;
  logic [31:0] fifo_data, tx_data;
  logic [1:0] hdr_toggle, hdr_ep_type, hdr_speed, done_status;
  logic [6:0] hdr_addr, hdr_ep;

  logic [3:0]  mtag [0:255];
  logic [31:0] mdat [0:255];
  logic [7:0]  wp = 8'd0, rp = 8'd0;
  assign fifo_empty = (wp == rp);
  assign fifo_tag   = mtag[rp];
  assign fifo_data  = mdat[rp];
  always @(posedge clk) if (fifo_rd && !fifo_empty) rp <= rp + 8'd1;

  logic [31:0] rxw [0:255];
  int rxn = 0, crcn = 0;
  always @(posedge clk) begin
    if (tx_valid) begin rxw[rxn[7:0]] <= tx_data; rxn <= rxn + 1; end
    if (tx_bad_crc) crcn <= crcn + 1;
  end

  host_pkt_cmd_engine #(.DATA_W(32), .TAG_W(4), .TOUT_CYC(TOUT)) dut (
    .clk(clk), .rst_n(rst_n), .run_pkt(run_pkt), .sof_req(sof_req), .sof_ack(sof_ack),
    .fifo_empty(fifo_empty), .fifo_tag(fifo_tag), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .hdr_valid(hdr_valid), .hdr_ack(hdr_ack), .hdr_pid(hdr_pid), .hdr_toggle(hdr_toggle),
    .hdr_ep_type(hdr_ep_type), .hdr_speed(hdr_speed), .hdr_addr(hdr_addr), .hdr_ep(hdr_ep),
    .phy_rdy(phy_rdy), .tx_valid(tx_valid), .tx_data(tx_data), .tx_bad_crc(tx_bad_crc),
    .done(done), .done_status(done_status));

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] tag, input logic [31:0] data);
    mtag[wp] = tag; mdat[wp] = data; wp = wp + 8'd1;
  endtask

  function automatic logic [7:0] fcount();
    return wp - rp;
  endfunction

  function automatic logic [31:0] mkcmd(input logic [3:0] pid, input logic [1:0] tog,
      input logic [1:0] typ, input logic [1:0] spd, input logic [6:0] addr, input logic [6:0] ep);
    return {2'b00, ep, addr, 6'b0, spd, typ, tog, pid};
  endfunction

  function automatic logic [3:0] pid_of(input int k);
    case (k)
      0: return 4'b0001; 1: return 4'b1001; 2: return 4'b1101; 3: return 4'b0100;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic logic [1:0] exp_status(input int k);
    return (k >= 4) ? 2'b10 : 2'b00;
  endfunction

  task automatic run_txn(input string req, input logic [31:0] cmd, input bit exp_hdr,
      input logic [1:0] exp_st, input int exp_words, input logic [31:0] pbase, input int stale);
    int start = rxn;
    bit hdr_seen = 0, hdr_bad = 0, sof_bad = 0, got = 0, pend = 0;
    logic [1:0] st_got = 2'b11;
    @(negedge clk);
    run_pkt = 1'b1;
    for (int t = 0; t < 600 && !got; t++) begin
      @(negedge clk);
      if (pend) begin
        pend = 0;
        push(4'd1, 32'hDEAD0001); push(4'd1, 32'hDEAD0002); push(4'd2, 32'h0);
        if (stale == 1) begin
          push(4'd0, mkcmd(4'b0001, 2'd1, 2'd2, 2'd0, 7'd5, 7'd3));
          push(4'd1, 32'h5A5A0000); push(4'd2, 32'h0);
        end
      end
      if (tx_bad_crc && stale != 0) pend = 1;
      if ((hdr_valid || tx_valid) && sof_ack) sof_bad = 1;
      if (hdr_valid) begin
        hdr_seen = 1;
        if (hdr_pid != cmd[3:0] || hdr_toggle != cmd[5:4] || hdr_ep_type != cmd[7:6] ||
            hdr_speed != cmd[9:8] || hdr_addr != cmd[22:16] || hdr_ep != cmd[29:23])
          hdr_bad = 1;
      end
      if (done) begin
        got = 1; st_got = done_status; run_pkt = 1'b0;
      end
      phy_rdy = (($urandom % 10) < 7);
      hdr_ack = hdr_valid && ($urandom % 2 == 1);
      sof_req = ($urandom % 4 == 0) && !got;
    end
    sof_req = 1'b0; hdr_ack = 1'b0; phy_rdy = 1'b0;
    chk({req, " R8"}, "done seen", longint'(got), 1);
    chk(req, "status", longint'(st_got), longint'(exp_st));
    chk({req, " R2/R10"}, "header presented", longint'(hdr_seen), longint'(exp_hdr));
    if (exp_hdr) chk({req, " R2"}, "header fields mismatch", longint'(hdr_bad), 0);
    chk({req, " R9"}, "sof grant while busy", longint'(sof_bad), 0);
    @(negedge clk);
    chk({req, " R8"}, "done single cycle", longint'(done), 0);
    chk({req, " R4"}, "payload words", longint'(rxn - start), longint'(exp_words));
    for (int i = 0; i < exp_words; i++)
      chk({req, " R4"}, "payload value", longint'(rxw[8'(start + i)]), longint'(pbase + 32'(i)));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] c;
    int c0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", longint'(done), 0);
    chk("R1", "fifo_rd", longint'(fifo_rd), 0);
    chk("R1", "hdr_valid", longint'(hdr_valid), 0);
    chk("R1", "tx_valid", longint'(tx_valid), 0);
    chk("R1", "tx_bad_crc", longint'(tx_bad_crc), 0);
    chk("R1", "sof_ack", longint'(sof_ack), 0);

    // R2 R4 OUT with payload
    c = mkcmd(4'b0001, 2'd2, 2'd2, 2'd1, 7'h55, 7'h2A);
    push(4'd0, c); for (int i = 0; i < 3; i++) push(4'd1, 32'h1000 + 32'(i)); push(4'd2, 0);
    run_txn("R4 OUT", c, 1, 2'b00, 3, 32'h1000, 0);
    chk("R4", "fifo drained", longint'(fcount()), 0);

    // R3 IN has no payload phase
    c = mkcmd(4'b1001, 2'd0, 2'd3, 2'd2, 7'h7F, 7'h7F);
    push(4'd0, c);
    run_txn("R3 IN", c, 1, 2'b00, 0, 0, 0);
    c = mkcmd(4'b1101, 2'd0, 2'd0, 2'd0, 7'h01, 7'h00);
    push(4'd0, c); push(4'd3, 32'h2000); push(4'd1, 32'h2001); push(4'd2, 0);
    run_txn("R3 SETUP", c, 1, 2'b00, 2, 32'h2000, 0);
    c = mkcmd(4'b0100, 2'd1, 2'd2, 2'd2, 7'h10, 7'h40);
    push(4'd0, c);
    run_txn("R3 PING", c, 1, 2'b00, 0, 0, 0);
    chk("R3", "fifo drained", longint'(fcount()), 0);

    // R7 command errors
    run_txn("R7 empty", 0, 0, 2'b10, 0, 0, 0);
    push(4'd1, 32'h0000_0001);
    run_txn("R7 bad tag", 0, 0, 2'b10, 0, 0, 0);
    chk("R7", "bad tag entry popped", longint'(fcount()), 0);
    push(4'd0, mkcmd(4'b0000, 0, 0, 0, 7'd3, 7'd3));
    run_txn("R7 bad pid", 0, 0, 2'b10, 0, 0, 0);
    chk("R7", "bad pid entry popped", longint'(fcount()), 0);

    // R9 SOF priority over a waiting request
    c = mkcmd(4'b1001, 0, 0, 0, 7'd9, 7'd1);
    push(4'd0, c);
    @(negedge clk);
    sof_req = 1'b1; run_pkt = 1'b1;
    #1;
    chk("R9", "sof_ack in idle", longint'(sof_ack), 1);
    chk("R9", "no pop on sof", longint'(fifo_rd), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R9", "sof blocks run", longint'(fcount()), 1);
    sof_req = 1'b0; run_pkt = 1'b0;
    run_txn("R9 after sof", c, 1, 2'b00, 0, 0, 0);

    // R5 R6 underrun, purge stops at retry command
    c0 = crcn;
    c = mkcmd(4'b0001, 2'd0, 2'd2, 2'd1, 7'd5, 7'd3);
    push(4'd0, c); push(4'd1, 32'h3000); push(4'd1, 32'h3001);
    run_txn("R6 underrun retry", c, 1, 2'b01, 2, 32'h3000, 1);
    chk("R5", "bad crc pulses", longint'(crcn - c0), 1);
    chk("R6", "entries kept after purge", longint'(fcount()), 3);
    chk("R6", "head is command", longint'(mtag[rp]), 0);
    run_txn("R6 retry", mkcmd(4'b0001, 2'd1, 2'd2, 2'd0, 7'd5, 7'd3), 1, 2'b00, 1, 32'h5A5A0000, 0);

    // R6 purge stops on empty
    c0 = crcn;
    c = mkcmd(4'b1101, 2'd0, 2'd0, 2'd2, 7'd6, 7'd2);
    push(4'd0, c); push(4'd1, 32'h4000);
    run_txn("R6 underrun empty", c, 1, 2'b01, 1, 32'h4000, 2);
    chk("R5", "bad crc pulses", longint'(crcn - c0), 1);
    chk("R6", "fifo purged", longint'(fcount()), 0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int k = int'($urandom % 6);
      int nw = int'($urandom % 5);
      logic [31:0] pb = $urandom & 32'hFFFF_FF00;
      logic [3:0] pid = pid_of(k);
      c = mkcmd(pid, 2'($urandom), 2'($urandom), 2'($urandom), 7'($urandom), 7'($urandom));
      if (k == 5) begin
        push(4'd1 + 4'($urandom % 14), c);
        run_txn("R7 rand tag", c, 0, 2'b10, 0, 0, 0);
      end else begin
        push(4'd0, c);
        if (k == 0 || k == 2) begin
          for (int i = 0; i < nw; i++) push(4'd1, pb + 32'(i));
          push(4'd2, 0);
        end else nw = 0;
        run_txn((k == 4) ? "R7 rand pid" : "R3 rand", c, k < 4, exp_status(k), nw, pb, 0);
      end
      chk("R4", "fifo drained", longint'(fcount()), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule